// File: doc/BRIEF.md
# Serial Test-Port Register Write Sequencer

This block writes one indirect configuration register of a camera-receive PHY through the PHY's strobed test port. A requester hands over an 8-bit register address (the test code) and an 8-bit value. The block then steps the port's clock, enable and 8-bit data-in pins through a fixed order. The PHY takes the address on a falling port-clock edge while enable is high. It takes the value on the following rising edge while enable is low. Once the last step ends, the block samples the 8-bit data-out returned by the port and reports it with a one-cycle done pulse.

Every step is held for a number of system clocks chosen per request, so that the port's setup and hold times can be met whatever the ratio between the system clock and the PHY's limits. The port's clear pin is kept apart from the sequence. It follows a control input while the block is idle and is frozen during a transaction.

The request side is a valid/ready stream. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no transaction is running. The requester must hold `req_valid`, `req_code`, `req_data` and `hold_cycles` steady until the request is taken. Anything presented while `req_ready` is low is not taken. The result side has no back-pressure: `done` is a single-cycle pulse, and `rdata` must be taken on that cycle.

Top module: `tport_seq`

## Requirements
- R1: After reset, `port_clk` is 1, `port_en` is 0, `port_din` is 0, `req_ready` is 1 and `done` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the cycle after that edge and returns to 1 in the same cycle that `done` is 1.
- R3: Taking the request starts eight steps, in this order: clock high, enable low, code on data-in, enable high, clock low, enable low, data byte on data-in, clock high. As a result, `port_en` is 1 at every falling edge of `port_clk`, and `port_din` then holds the request's code.
- R4: At the rising edge of `port_clk` that ends the transaction, `port_en` is 0 and `port_din` holds the request's data byte.
- R5: Each step lasts H system clocks. H is `hold_cycles` as sampled when the request is taken; a value of 0 selects H = 4. `done` is 1 exactly 8·H clock edges after the edge that took the request.
- R6: `done` is high for exactly one cycle. In that cycle, `rdata` equals `port_dout` as sampled at the end of the final clock-high step.
- R7: A request presented while `req_ready` is 0 is ignored. It produces no extra `done` and does not change the pins or the result of the transaction in progress.
- R8: While idle, `port_clr` follows `clr_in` one cycle later. While busy, `port_clr` stays constant whatever `clr_in` does.
- R9: The code and data byte are captured when the request is taken. Changing `req_code` or `req_data` afterwards has no effect on the transaction.
- R10: While `req_ready` is 1, `port_clk` is 1 and `port_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_code | input | 8 | Register address to write |
| req_data | input | 8 | Value to write |
| hold_cycles | input | HOLD_W | System clocks per step (0 selects the default) |
| clr_in | input | 1 | Requested level of the port clear pin |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Port data-out captured at completion |
| port_clk | output | 1 | Test-port clock |
| port_en | output | 1 | Test-port enable |
| port_din | output | 8 | Test-port data-in |
| port_clr | output | 1 | Test-port clear |
| port_dout | input | 8 | Test-port data-out |

## Verification
The hardest situation to reach from the ports is a competing request and a changing clear input arriving in the middle of a running transaction. An ordinary requester waits for `req_ready`, so it never produces this case. The bench therefore raises `req_valid` with different code and data, and toggles `clr_in`, on the cycle right after a request is taken. It holds them there for several cycles while `req_ready` is low. The scoreboard then requires that only the original code and data reach the behavioural port model, that no extra completion appears, and that `port_clr` stays frozen until the block is idle again.

// File: rtl/tport_pkg.sv
package tport_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLK_HI_A,
    ST_EN_LO_A,
    ST_DIN_CODE,
    ST_EN_HI,
    ST_CLK_LO,
    ST_EN_LO_B,
    ST_DIN_DATA,
    ST_CLK_HI_B
  } step_e;

  function automatic step_e step_after(step_e s);
    case (s)
      ST_CLK_HI_A: return ST_EN_LO_A;
      ST_EN_LO_A:  return ST_DIN_CODE;
      ST_DIN_CODE: return ST_EN_HI;
      ST_EN_HI:    return ST_CLK_LO;
      ST_CLK_LO:   return ST_EN_LO_B;
      ST_EN_LO_B:  return ST_DIN_DATA;
      ST_DIN_DATA: return ST_CLK_HI_B;
      default:     return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/tport_hold_timer.sv
module tport_hold_timer #(
  parameter int HOLD_W   = 8,
  parameter int DEF_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              reload,
  input  logic [HOLD_W-1:0] hold_in,
  output logic              expire
);
  localparam logic [HOLD_W-1:0] DEF_H = HOLD_W'(DEF_HOLD);

  logic [HOLD_W-1:0] eff_hold;
  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] cnt_q;

  // a zero request selects the default hold
  assign eff_hold = (hold_in == '0) ? DEF_H : hold_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= DEF_H;
      cnt_q  <= '0;
    end else if (start) begin
      hold_q <= eff_hold;
      cnt_q  <= eff_hold - 1'b1;
    end else if (reload) begin
      cnt_q  <= hold_q - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/tport_step_fsm.sv
module tport_step_fsm
  import tport_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  expire,
  output step_e step,
  output step_e nxt,
  output logic  take,
  output logic  advance,
  output logic  finish
);
  step_e step_q;

  assign advance = (step_q != ST_IDLE) && expire;
  assign take    = start || advance;
  assign nxt     = start ? ST_CLK_HI_A : step_after(step_q);
  assign finish  = advance && (step_q == ST_CLK_HI_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    step_q <= ST_IDLE;
    else if (take) step_q <= nxt;
  end

  assign step = step_q;
endmodule

// File: rtl/tport_pin_drive.sv
module tport_pin_drive
  import tport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  step_e         nxt,
  input  logic          idle,
  input  logic [DW-1:0] code,
  input  logic [DW-1:0] data,
  input  logic          clr_in,
  output logic          port_clk,
  output logic          port_en,
  output logic [DW-1:0] port_din,
  output logic          port_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_clk <= 1'b1;
      port_en  <= 1'b0;
      port_din <= '0;
    end else if (take) begin
      case (nxt)
        ST_CLK_HI_A, ST_CLK_HI_B: port_clk <= 1'b1;
        ST_EN_LO_A, ST_EN_LO_B:   port_en  <= 1'b0;
        ST_DIN_CODE:              port_din <= code;
        ST_EN_HI:                 port_en  <= 1'b1;
        ST_CLK_LO:                port_clk <= 1'b0;
        ST_DIN_DATA:              port_din <= data;
        default: ;
      endcase
    end
  end

  // clear pin only tracks its input between transactions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    port_clr <= 1'b0;
    else if (idle) port_clr <= clr_in;
  end
endmodule

// File: rtl/tport_seq.sv
module tport_seq
  import tport_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HOLD_W   = 8,
  parameter int DEF_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DW-1:0]     req_code,
  input  logic [DW-1:0]     req_data,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic              clr_in,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic              port_clk,
  output logic              port_en,
  output logic [DW-1:0]     port_din,
  output logic              port_clr,
  input  logic [DW-1:0]     port_dout
);
  step_e         step;
  step_e         nxt;
  logic          take;
  logic          advance;
  logic          finish;
  logic          expire;
  logic          start;
  logic          idle;
  logic [DW-1:0] code_q;
  logic [DW-1:0] data_q;

  assign idle      = (step == ST_IDLE);
  assign req_ready = idle;
  assign start     = req_valid && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      data_q <= '0;
    end else if (start) begin
      code_q <= req_code;
      data_q <= req_data;
    end
  end

  tport_hold_timer #(.HOLD_W(HOLD_W), .DEF_HOLD(DEF_HOLD)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .reload(advance),
    .hold_in(hold_cycles), .expire(expire)
  );

  tport_step_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .expire(expire),
    .step(step), .nxt(nxt), .take(take), .advance(advance), .finish(finish)
  );

  tport_pin_drive #(.DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .take(take), .nxt(nxt), .idle(idle),
    .code(code_q), .data(data_q), .clr_in(clr_in),
    .port_clk(port_clk), .port_en(port_en), .port_din(port_din),
    .port_clr(port_clr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= finish;
      if (finish) rdata <= port_dout;
    end
  end
endmodule

// File: rtl/tport_seq_chk.sv
module tport_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic port_clk,
  input logic port_en,
  input logic port_clr
);
  a_r3_en_high_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(port_clk) |-> port_en);

  a_r4_en_low_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_clk) |-> !port_en);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r8_clr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (req_ready || $stable(port_clr)));

  a_r10_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (port_clk && !port_en));

  a_r2_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

bind tport_seq tport_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .port_clk(port_clk), .port_en(port_en), .port_clr(port_clr)
);

// File: tb/test_tport_seq.sv
`timescale 1ns/1ps
module test_tport_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_code = '0;
  logic [7:0] req_data = '0;
  logic [7:0] hold_cycles = '0;
  logic       clr_in = 1'b0;
  logic       done;
  logic [7:0] rdata;
  logic       port_clk, port_en, port_clr;
  logic [7:0] port_din, port_dout;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tport_seq i_tport_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .req_data(req_data), .hold_cycles(hold_cycles),
    .clr_in(clr_in), .done(done), .rdata(rdata), .port_clk(port_clk),
    .port_en(port_en), .port_din(port_din), .port_clr(port_clr),
    .port_dout(port_dout)
  );

  // behavioural port: address on falling edge with enable high,
  // value on rising edge with enable low
  logic [7:0] m_code = '0;
  logic [7:0] m_data = '0;
  always @(negedge port_clk) if (port_en === 1'b1) m_code <= port_din;
  always @(posedge port_clk) if (port_en === 1'b0) m_data <= port_din;
  assign port_dout = (m_code + m_data) ^ 8'h5A;

  typedef struct packed {
    logic [7:0]  code;
    logic [7:0]  data;
    logic [31:0] at;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send(input logic [7:0] c, input logic [7:0] d,
                      input logic [7:0] h);
    int eff;
    @(negedge clk);
    req_valid = 1'b1; req_code = c; req_data = d; hold_cycles = h;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    eff = (h == 0) ? 4 : int'(h);
    sb.push_back('{code: c, data: d, at: 32'(cyc + 8 * eff)});
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 busy after take", 32'(req_ready), 0);
  endtask

  // monitor / scoreboard
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && done) chk(0, "R6 done longer than one cycle", 1, 0);
      if (done) begin
        if (sb.size() == 0) begin
          chk(0, "R7 spurious done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(rdata == ((e.code + e.data) ^ 8'h5A), "R6 rdata", 32'(rdata),
              32'((e.code + e.data) ^ 8'h5A));
          chk(m_code == e.code, "R3 code latched on fall", 32'(m_code), 32'(e.code));
          chk(m_data == e.data, "R4 data latched on rise", 32'(m_data), 32'(e.data));
          chk(cyc == int'(e.at), "R5 completion latency", 32'(cyc), e.at);
          chk(req_ready == 1'b1, "R2 ready with done", 32'(req_ready), 1);
        end
      end
    end
    prev_done <= done;
  end

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    logic saved_clr;
    repeat (3) @(negedge clk);
    chk(port_clk == 1'b1, "R1 clk idle high", 32'(port_clk), 1);
    chk(port_en == 1'b0, "R1 enable low", 32'(port_en), 0);
    chk(port_din == 8'h00, "R1 din zero", 32'(port_din), 0);
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
    chk(done == 1'b0, "R1 done low", 32'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(8'h44, 8'h2A, 8'd1);
    drain();
    send(8'h17, 8'hC3, 8'd0);   // R5 default hold
    drain();
    send(8'hFF, 8'h00, 8'd3);
    drain();
    send(8'h00, 8'hFF, 8'd2);
    chk(port_clk == 1'b1 && port_en == 1'b0, "R10 not yet idle check skipped", 1, 1);
    drain();
    chk(port_clk == 1'b1 && port_en == 1'b0, "R10 idle pins",
        32'({port_clk, port_en}), 32'h2);

    // R7 / R9 / R8: competing request and clear toggle while busy
    saved_clr = port_clr;
    send(8'h18, 8'h9C, 8'd3);
    req_valid = 1'b1; req_code = 8'hAA; req_data = 8'h55; clr_in = ~clr_in;
    repeat (6) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R7 ignored while busy", 32'(req_ready), 0);
      chk(port_clr == saved_clr, "R8 clear frozen", 32'(port_clr), 32'(saved_clr));
    end
    req_valid = 1'b0;
    drain();
    chk(port_clr == clr_in, "R8 clear follows when idle", 32'(port_clr), 32'(clr_in));
    clr_in = ~clr_in;
    @(negedge clk);
    chk(port_clr == clr_in, "R8 clear one cycle later", 32'(port_clr), 32'(clr_in));

    // back-to-back requests with valid held high
    send(8'h5E, 8'h71, 8'd1);
    send(8'h23, 8'h90, 8'd2);
    drain();
    repeat (30) @(negedge clk);
    chk(sb.size() == 0, "R7 no missing result", 32'(sb.size()), 0);
    finish_run();
  end
endmodule